// File: doc/BRIEF.md
# Discrete Cartridge Bank-Switching Controller

This block is the address-steering logic of a game cartridge whose whole mapper state sits in one write-only 8-bit register. The CPU stores a byte anywhere in its ROM window; the byte's fields then pick a 16 KB program bank for the lower CPU window, an 8 KB character (pattern) bank for the video side, and the nametable mirroring arrangement. The upper 16 KB CPU window is pinned to the last program bank, because every program-bank bit is OR-ed with CPU address line A14.

On the video side, nametable RAM address bit 10 comes from a 2-to-1 multiplexer: video A10 (vertical arrangement) or video A11 (horizontal arrangement), selected by the latched mirroring bit. The block also makes the active-low enable for a bus buffer that carries character data onto the video data bus. It drives only for reads of the pattern region below 0x2000. The character ROM itself is treated as always enabled.

All paths are plain control pins: no data stream passes through the block, so there is no valid/ready handshake and no back-pressure. The register is the only state. It runs on the system clock, with a synchronous reset and edge detection on the CPU write strobe.

Top module: `cart_bank_mapper`

## Requirements
- R1: A synchronous reset clears the register. In the cycle after reset is seen, chr_hi is 0, prg_hi is 0 while cpu_a14 is 0, and ciram_a10 follows ppu_a10.
- R2: While cpu_a14 is 0, prg_hi equals register bits [2:0].
- R3: While cpu_a14 is 1, prg_hi is all ones, whatever the register holds.
- R4: chr_hi equals register bits [7:4] at all times, with no gating by any video or CPU signal.
- R5: When register bit 3 is 0, ciram_a10 equals ppu_a10.
- R6: When register bit 3 is 1, ciram_a10 equals ppu_a11.
- R7: chr_buf_oe_n is 0 exactly when ppu_a13 is 0 and ppu_rd_n is 0; otherwise it is 1.
- R8: The register loads cpu_data at the clock edge where cpu_wr is first seen high after being low, provided cpu_romsel_n is 0 at that edge. The new value appears at the outputs after that edge. Holding cpu_wr high for more cycles loads nothing further.
- R9: A rising cpu_wr seen while cpu_romsel_n is 1 leaves the register, and so every output field, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_a14 | input | 1 | CPU address line A14 (upper/lower 16 KB window) |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, active high |
| cpu_romsel_n | input | 1 | Low while the CPU addresses 0x8000-0xFFFF |
| ppu_a10 | input | 1 | Video address A10 |
| ppu_a11 | input | 1 | Video address A11 |
| ppu_a13 | input | 1 | Video address A13 |
| ppu_rd_n | input | 1 | Video read strobe, active low |
| prg_hi | output | 3 | Program-ROM upper address bits |
| chr_hi | output | 4 | Character-ROM upper address bits |
| ciram_a10 | output | 1 | Nametable RAM address bit 10 |
| chr_buf_oe_n | output | 1 | Character-data buffer enable, active low |

## Verification
The assertions assume the inputs are synchronous to clk. They also assume that rst is held high long enough for at least one edge before any write matters, so the checker's shadow of the mirroring and program fields starts from the same cleared value as the register. The bench keeps cpu_wr low through reset and changes every input only at the falling edge. Each strobe level and ROM-select value is therefore seen stable at the next rising edge, with no setup race.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  parameter int PRG_BITS = 3;
  parameter int CHR_BITS = 4;
  localparam int REG_W      = PRG_BITS + 1 + CHR_BITS;
  localparam int MIRROR_POS = PRG_BITS;
  localparam int CHR_LSB    = PRG_BITS + 1;

  typedef struct packed {
    logic [CHR_BITS-1:0] chr_bank;
    logic                horiz;
    logic [PRG_BITS-1:0] prg_bank;
  } bank_reg_t;
endpackage

// File: rtl/bank_latch.sv
module bank_latch
  import cart_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             sel_n,
  input  logic [REG_W-1:0] din,
  output bank_reg_t        q
);
  logic wr_prev;
  logic wr_rise;

  assign wr_rise = wr & ~wr_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b0;
      q       <= '0;
    end else begin
      wr_prev <= wr;
      if (wr_rise && !sel_n) q <= bank_reg_t'(din);
    end
  end
endmodule

// File: rtl/prg_addr_gate.sv
module prg_addr_gate #(
  parameter int N = 3
) (
  input  logic [N-1:0] bank,
  input  logic         a14,
  output logic [N-1:0] hi
);
  for (genvar i = 0; i < N; i++) begin : g_or
    assign hi[i] = bank[i] | a14;
  end
endmodule

// File: rtl/nametable_mux.sv
module nametable_mux (
  input  logic sel_horiz,
  input  logic a10,
  input  logic a11,
  output logic y
);
  always_comb begin
    if (sel_horiz) y = a11;
    else           y = a10;
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_bank_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_a14,
  input  logic [REG_W-1:0]    cpu_data,
  input  logic                cpu_wr,
  input  logic                cpu_romsel_n,
  input  logic                ppu_a10,
  input  logic                ppu_a11,
  input  logic                ppu_a13,
  input  logic                ppu_rd_n,
  output logic [PRG_BITS-1:0] prg_hi,
  output logic [CHR_BITS-1:0] chr_hi,
  output logic                ciram_a10,
  output logic                chr_buf_oe_n
);
  bank_reg_t state;

  bank_latch u_latch (
    .clk   (clk),
    .rst   (rst),
    .wr    (cpu_wr),
    .sel_n (cpu_romsel_n),
    .din   (cpu_data),
    .q     (state)
  );

  prg_addr_gate #(.N(PRG_BITS)) u_prg (
    .bank (state.prg_bank),
    .a14  (cpu_a14),
    .hi   (prg_hi)
  );

  nametable_mux u_nt (
    .sel_horiz (state.horiz),
    .a10       (ppu_a10),
    .a11       (ppu_a11),
    .y         (ciram_a10)
  );

  assign chr_hi       = state.chr_bank;
  assign chr_buf_oe_n = ppu_a13 | ppu_rd_n;
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import cart_bank_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cpu_a14,
  input logic [REG_W-1:0]    cpu_data,
  input logic                cpu_wr,
  input logic                cpu_romsel_n,
  input logic                ppu_a10,
  input logic                ppu_a11,
  input logic                ppu_a13,
  input logic                ppu_rd_n,
  input logic [PRG_BITS-1:0] prg_hi,
  input logic [CHR_BITS-1:0] chr_hi,
  input logic                ciram_a10,
  input logic                chr_buf_oe_n
);
  logic                wr_seen;
  logic                m_sh;
  logic [PRG_BITS-1:0] p_sh;
  logic                load_evt;

  assign load_evt = cpu_wr && !wr_seen && !cpu_romsel_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen <= 1'b0;
      m_sh    <= 1'b0;
      p_sh    <= '0;
    end else begin
      wr_seen <= cpu_wr;
      if (load_evt) begin
        m_sh <= cpu_data[MIRROR_POS];
        p_sh <= cpu_data[PRG_BITS-1:0];
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (chr_hi == '0));
  a_r2_lower_window: assert property (@(posedge clk) disable iff (rst)
    !cpu_a14 |-> (prg_hi == p_sh));
  a_r3_upper_window: assert property (@(posedge clk) disable iff (rst)
    cpu_a14 |-> (&prg_hi));
  a_r5_vertical: assert property (@(posedge clk) disable iff (rst)
    !m_sh |-> (ciram_a10 == ppu_a10));
  a_r6_horizontal: assert property (@(posedge clk) disable iff (rst)
    m_sh |-> (ciram_a10 == ppu_a11));
  a_r7_buf_on: assert property (@(posedge clk) disable iff (rst)
    (!ppu_a13 && !ppu_rd_n) |-> !chr_buf_oe_n);
  a_r7_buf_off: assert property (@(posedge clk) disable iff (rst)
    (ppu_a13 || ppu_rd_n) |-> chr_buf_oe_n);
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (chr_hi == $past(cpu_data[REG_W-1:CHR_LSB])));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(chr_hi));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (.*);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_a14 = 1'b0;
  logic [7:0] cpu_data = 8'h00;
  logic       cpu_wr = 1'b0;
  logic       cpu_romsel_n = 1'b1;
  logic       ppu_a10 = 1'b0, ppu_a11 = 1'b0, ppu_a13 = 1'b1, ppu_rd_n = 1'b1;
  logic [2:0] prg_hi;
  logic [3:0] chr_hi;
  logic       ciram_a10, chr_buf_oe_n;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag_override = "";

  // behavioural reference state
  int ref_reg = 0;
  bit ref_prev = 0;

  always #2 clk = ~clk;

  cart_bank_mapper dut (.*);

  always @(posedge clk) begin
    if (rst) begin
      ref_reg  <= 0;
      ref_prev <= 0;
    end else begin
      if (cpu_wr && !ref_prev && !cpu_romsel_n) ref_reg <= int'(cpu_data);
      ref_prev <= cpu_wr;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_prg, exp_chr, exp_nt, exp_oe;
    bit horiz;
    horiz   = ((ref_reg >> 3) & 1) != 0;
    exp_prg = cpu_a14 ? 7 : (ref_reg & 7);
    exp_chr = (ref_reg >> 4) & 15;
    exp_nt  = horiz ? int'(ppu_a11) : int'(ppu_a10);
    exp_oe  = (ppu_a13 || ppu_rd_n) ? 1 : 0;
    check(tag_override != "" ? tag_override : (cpu_a14 ? "R3" : "R2"), int'(prg_hi), exp_prg);
    check(tag_override != "" ? tag_override : "R4", int'(chr_hi), exp_chr);
    check(horiz ? "R6" : "R5", int'(ciram_a10), exp_nt);
    check("R7", int'(chr_buf_oe_n), exp_oe);
  endtask

  // one cycle: drive at falling edge, compare 1 ns later
  task automatic cyc(bit wr, bit rs_n, logic [7:0] d);
    @(negedge clk);
    cpu_wr = wr; cpu_romsel_n = rs_n; cpu_data = d;
    cpu_a14 = 1'($urandom); ppu_a10 = 1'($urandom); ppu_a11 = 1'($urandom);
    ppu_a13 = 1'($urandom); ppu_rd_n = 1'($urandom);
    #1;
    if (!rst) compare_all();
  endtask

  task automatic cpu_write(logic [7:0] d, bit rs_n);
    cyc(1'b1, rs_n, d);
    cyc(1'b0, rs_n, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag_override = "R1";
    repeat (4) cyc(1'b0, 1'b1, 8'h00);
    tag_override = "";
    cpu_write(8'h35, 1'b0);   // prg 5, vertical, chr 3
    repeat (6) cyc(1'b0, 1'b1, 8'h00);
    cpu_write(8'hAA, 1'b0);   // prg 2, horizontal, chr 10
    repeat (6) cyc(1'b0, 1'b1, 8'h00);
    cpu_write(8'hFF, 1'b0);
    repeat (4) cyc(1'b0, 1'b1, 8'h00);
    tag_override = "R9";      // writes outside the ROM window
    cpu_write(8'h10, 1'b1);
    repeat (4) cyc(1'b0, 1'b1, 8'h00);
    tag_override = "";
    cpu_write(8'h42, 1'b0);
    tag_override = "R8";      // held strobe: only the first edge loads
    cyc(1'b1, 1'b0, 8'h97);
    cyc(1'b1, 1'b0, 8'h6C);
    cyc(1'b1, 1'b0, 8'h1E);
    cyc(1'b0, 1'b0, 8'h00);
    repeat (3) cyc(1'b0, 1'b1, 8'h00);
    tag_override = "";
    for (int i = 0; i < 400; i++)
      cyc(1'($urandom), 1'($urandom), 8'($urandom));
    tag_override = "R1";
    @(negedge clk); rst = 1'b1; cpu_wr = 1'b0;
    @(negedge clk); rst = 1'b0;
    repeat (3) cyc(1'b0, 1'b1, 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule